// File: doc/BRIEF.md
# Expansion-Bus I/O Port Target

This block sits on the peripheral side of an 8/16-bit PC expansion bus and presents a small bank of 16-bit registers in I/O port space. It watches the port address, the active-low read and write strobes and the DMA ownership flag. When a strobe hits one of its ports, it drives the addressed register onto the data bus or stores the bus data into that register.

Register `i` sits at port `BASE + 2*i`. The low byte lane belongs to even addresses and the high byte lane is qualified by the active-low byte-high enable. A local busy input lets nearby logic stretch a cycle by pulling the channel-ready line low, and a hard cap bounds that stretch. One-cycle local pulses report each completed read or write, together with the register index. The bidirectional data bus is split into an input, an output and a per-lane output enable.

Top module: `io_port_target`

## Requirements
- R1: A port hits when `aen` is low and `addr` (all 16 bits) lies in `[BASE, BASE+2*NREG)`; `iocs16_n` is low exactly while a hit is decoded, and register index is `(addr-BASE)>>1`.
- R2: While `aen` is high nothing is decoded: `iocs16_n` stays high, `data_oe` stays `00`, no register changes, no local pulse fires and `chrdy` stays high.
- R3: During a hit with `ior_n` low, `data_out` carries the addressed register, `data_oe[0]` is high when `addr[0]` is 0 and `data_oe[1]` is high when `sbhe_n` is 0; otherwise `data_oe` is `00`.
- R4: A hit write stores `data_in[7:0]` into the low byte when `addr[0]` is 0 and `data_in[15:8]` into the high byte when `sbhe_n` is 0, leaving any unselected byte unchanged; `reg_bank[16*i +: 16]` shows register `i`.
- R5: If `loc_busy` is high on the first clock edge of a hit strobe, `chrdy` goes low from the next cycle and stays low until the edge on which `loc_busy` is seen low; the write or read completes on that edge.
- R6: `chrdy` is never low for more than `WAIT_CAP` (17) consecutive cycles; with `loc_busy` held high it is low for exactly `WAIT_CAP` cycles and the access then completes anyway.
- R7: `reset_drv` high clears every register to zero, releases `chrdy` high and returns the cycle tracker to idle, including in the middle of a stretched cycle.
- R8: Each hit strobe completes exactly once however long it is held: one single-cycle `loc_wr` (write) or `loc_rd` (read) pulse, with `loc_idx` giving the register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| reset_drv | input | 1 | Bus reset, active high, asynchronous |
| addr | input | 16 | Port address |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| aen | input | 1 | DMA owns the bus when high |
| sbhe_n | input | 1 | High byte lane enable, active low |
| data_in | input | 16 | Data bus as received |
| data_out | output | 16 | Data bus value to drive |
| data_oe | output | 2 | Drive enable per byte lane (bit 1 high byte) |
| chrdy | output | 1 | Channel ready, low requests wait states |
| iocs16_n | output | 1 | 16-bit port cycle indication, active low |
| loc_busy | input | 1 | Local side requests wait states |
| loc_rd | output | 1 | One-cycle pulse on completed read |
| loc_wr | output | 1 | One-cycle pulse on completed write |
| loc_idx | output | IDXW | Index of the register last accessed |
| reg_bank | output | 16*NREG | All registers, register 0 in the low bits |

## Verification
The bench probes the first and last ports of the window and the ports just outside it. A design that is off by one in the range check claims a neighbour's port or misses its own top register. Stuck-busy accesses check that the stretch ends at exactly the cap, since a counter that starts at zero or compares with the wrong bound yields 16 or 18 low cycles. Byte-lane writes and DMA-owned writes follow each write with a readback, which exposes a design that clobbers the unselected byte or obeys strobes while `aen` is high. Held strobes confirm a single local pulse, and a reset in the middle of a wait checks that ready is released at once.

// File: rtl/io_port_target.sv
module io_port_target #(
  parameter logic [15:0] BASE     = 16'h0300,
  parameter int          NREG     = 4,
  parameter int          WAIT_CAP = 17,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CNTW = $clog2(WAIT_CAP + 1)
) (
  input  logic                 clk,
  input  logic                 reset_drv,
  input  logic [15:0]          addr,
  input  logic                 ior_n,
  input  logic                 iow_n,
  input  logic                 aen,
  input  logic                 sbhe_n,
  input  logic [15:0]          data_in,
  output logic [15:0]          data_out,
  output logic [1:0]           data_oe,
  output logic                 chrdy,
  output logic                 iocs16_n,
  input  logic                 loc_busy,
  output logic                 loc_rd,
  output logic                 loc_wr,
  output logic [IDXW-1:0]      loc_idx,
  output logic [16*NREG-1:0]   reg_bank
);

  localparam logic [16:0] LO_LIM = {1'b0, BASE};
  localparam logic [16:0] HI_LIM = {1'b0, BASE} + 17'(2 * NREG);
  localparam logic [CNTW-1:0] CAP = CNTW'(WAIT_CAP);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;

  st_t             st;
  logic [CNTW-1:0] cnt;
  logic [15:0]     regs [NREG];

  logic [15:0]     offs;
  logic [IDXW-1:0] idx;
  logic            hit, rd_act, act, lane_lo, lane_hi, start, fire;

  assign offs    = addr - BASE;
  assign idx     = offs[IDXW:1];
  assign hit     = !aen && ({1'b0, addr} >= LO_LIM) && ({1'b0, addr} < HI_LIM);
  assign rd_act  = !ior_n;
  assign act     = !ior_n || !iow_n;
  assign lane_lo = !addr[0];
  assign lane_hi = !sbhe_n;

  assign iocs16_n = !hit;
  assign data_oe  = (hit && rd_act) ? {lane_hi, lane_lo} : 2'b00;
  assign data_out = hit ? regs[idx] : 16'h0000;
  assign chrdy    = (st != S_WAIT);

  assign start = (st == S_IDLE) && hit && act;
  assign fire  = (start && !loc_busy) ||
                 ((st == S_WAIT) && hit && act && (!loc_busy || cnt == CAP));

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    assign reg_bank[16*g +: 16] = regs[g];
  end

  always_ff @(posedge clk or posedge reset_drv) begin
    if (reset_drv) begin
      st      <= S_IDLE;
      cnt     <= '0;
      loc_rd  <= 1'b0;
      loc_wr  <= 1'b0;
      loc_idx <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= 16'h0000;
    end else begin
      loc_rd <= 1'b0;
      loc_wr <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (loc_busy) begin
            st  <= S_WAIT;
            cnt <= CNTW'(1);
          end else begin
            st <= S_DONE;
          end
        end
        S_WAIT: begin
          if (!(hit && act))                    st  <= S_IDLE;
          else if (!loc_busy || cnt == CAP)     st  <= S_DONE;
          else                                  cnt <= cnt + CNTW'(1);
        end
        S_DONE: if (!act) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (fire) begin
        loc_idx <= idx;
        if (rd_act) begin
          loc_rd <= 1'b1;
        end else begin
          loc_wr <= 1'b1;
          if (lane_lo) regs[idx][7:0]  <= data_in[7:0];
          if (lane_hi) regs[idx][15:8] <= data_in[15:8];
        end
      end
    end
  end

  logic [7:0] low_run;
  always_ff @(posedge clk or posedge reset_drv) begin
    if (reset_drv)   low_run <= '0;
    else if (!chrdy) low_run <= low_run + 8'd1;
    else             low_run <= '0;
  end

  a_r6_wait_cap: assert property (@(posedge clk) disable iff (reset_drv)
    !chrdy |-> (low_run < 8'(WAIT_CAP)));

  a_r2_aen_quiet: assert property (@(posedge clk) disable iff (reset_drv)
    aen |-> (iocs16_n && data_oe == 2'b00));

  a_r3_oe_only_on_read: assert property (@(posedge clk) disable iff (reset_drv)
    (data_oe != 2'b00) |-> (!ior_n && !aen && !iocs16_n));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (reset_drv)
    (loc_wr || loc_rd) |=> !(loc_wr || loc_rd));

  a_r8_not_both: assert property (@(posedge clk) disable iff (reset_drv)
    !(loc_wr && loc_rd));

  a_r5_wait_entry: assert property (@(posedge clk) disable iff (reset_drv)
    (chrdy && !iocs16_n && (!ior_n || !iow_n) && loc_busy && !$past(!iocs16_n && (!ior_n || !iow_n))) |=> !chrdy);

  a_r4_write_needs_strobe: assert property (@(posedge clk) disable iff (reset_drv)
    loc_wr |-> $past(!iow_n && !aen));

endmodule

// File: tb/sim_io_port_target.sv
`timescale 1ns/1ps
module sim_io_port_target;
  localparam logic [15:0] BASE = 16'h0300;
  localparam int NREG = 4;
  localparam int CAP  = 17;
  localparam int IDXW = 2;

  logic clk = 1'b0;
  logic reset_drv = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0, sbhe_n = 1'b1, loc_busy = 1'b0;
  logic [15:0] data_in = 16'h0000;
  logic [15:0] data_out;
  logic [1:0] data_oe;
  logic chrdy, iocs16_n, loc_rd, loc_wr;
  logic [IDXW-1:0] loc_idx;
  logic [16*NREG-1:0] reg_bank;

  io_port_target #(.BASE(BASE), .NREG(NREG), .WAIT_CAP(CAP)) u0 (
    .clk(clk), .reset_drv(reset_drv), .addr(addr), .ior_n(ior_n), .iow_n(iow_n),
    .aen(aen), .sbhe_n(sbhe_n), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .chrdy(chrdy), .iocs16_n(iocs16_n), .loc_busy(loc_busy),
    .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_idx(loc_idx), .reg_bank(reg_bank));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  logic [15:0] model [NREG];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [15:0] a, input bit ae);
    return !ae && (a >= BASE) && (a < BASE + 16'(2*NREG));
  endfunction

  function automatic int exp_low(input bit h, input int blen);
    if (!h) return 0;
    return (blen < CAP) ? blen : CAP;
  endfunction

  task automatic check_bank(input string tag);
    logic [16*NREG-1:0] e;
    for (int i = 0; i < NREG; i++) e[16*i +: 16] = model[i];
    chk(reg_bank == e, tag, reg_bank, e);
  endtask

  task automatic do_op(input bit rd, input logic [15:0] a, input logic [15:0] d,
                       input bit sb, input bit ae, input int blen, input int hold);
    bit h;
    int low, pulses, ix;
    logic [1:0] eoe;
    h = exp_hit(a, ae);
    ix = int'((a - BASE) >> 1);
    @(negedge clk);
    addr = a; data_in = d; sbhe_n = sb; aen = ae; loc_busy = (blen > 0);
    if (rd) ior_n = 1'b0; else iow_n = 1'b0;
    #1;
    chk(iocs16_n == !h, "R1/R2 iocs16_n", iocs16_n, !h);
    eoe = (h && rd) ? {!sb, !a[0]} : 2'b00;
    chk(data_oe == eoe, "R3 data_oe", data_oe, eoe);
    if (h && rd) chk(data_out == model[ix], "R3 data_out", data_out, model[ix]);
    low = 0; pulses = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rd ? loc_rd : loc_wr) begin
        pulses++;
        chk(loc_idx == IDXW'(ix), "R8 loc_idx", loc_idx, ix);
      end
      if (!rd && loc_rd) pulses += 100;
      if (rd && loc_wr) pulses += 100;
      if (!chrdy) begin
        low++;
        if (low >= blen) loc_busy = 1'b0;
      end else break;
    end
    chk(low == exp_low(h, blen), "R5/R6 chrdy low cycles", low, exp_low(h, blen));
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (loc_rd || loc_wr) pulses++;
      if (!chrdy) low++;
    end
    ior_n = 1'b1; iow_n = 1'b1; loc_busy = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (loc_rd || loc_wr) pulses++;
    end
    chk(pulses == (h ? 1 : 0), "R8/R2 local pulse count", pulses, h ? 1 : 0);
    if (h && !rd) begin
      if (!a[0]) model[ix][7:0]  = d[7:0];
      if (!sb)   model[ix][15:8] = d[15:8];
    end
    check_bank("R4/R2 register bank");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    reset_drv = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk(chrdy == 1'b1, "R7 chrdy after reset", chrdy, 1);
    chk(data_oe == 2'b00, "R7 data_oe after reset", data_oe, 0);
    check_bank("R7 bank cleared");

    // R1 R4 R3 directed full and byte accesses
    do_op(0, BASE, 16'hA55A, 0, 0, 0, 0);
    do_op(1, BASE, 16'h0000, 0, 0, 0, 0);
    do_op(0, BASE + 16'd2, 16'h1234, 1, 0, 0, 0);
    do_op(0, BASE + 16'd3, 16'hBEEF, 0, 0, 0, 0);
    do_op(1, BASE + 16'd2, 16'h0000, 0, 0, 0, 0);
    do_op(1, BASE + 16'd3, 16'h0000, 0, 0, 0, 0);
    // R1 boundaries
    do_op(0, BASE - 16'd1, 16'hFFFF, 0, 0, 0, 0);
    do_op(0, BASE + 16'(2*NREG), 16'hFFFF, 0, 0, 0, 0);
    do_op(0, BASE + 16'(2*NREG) - 16'd2, 16'hC0DE, 0, 0, 0, 0);
    do_op(1, BASE + 16'(2*NREG) - 16'd2, 16'h0000, 0, 0, 0, 0);
    // R2 DMA owns bus
    do_op(0, BASE, 16'h7777, 0, 1, 5, 0);
    do_op(1, BASE, 16'h0000, 0, 1, 0, 0);
    // R5 wait, R6 cap
    do_op(0, BASE + 16'd4, 16'h4321, 0, 0, 5, 0);
    do_op(0, BASE + 16'd4, 16'h9999, 0, 0, 60, 0);
    do_op(1, BASE + 16'd4, 16'h0000, 0, 0, 60, 0);
    do_op(0, BASE, 16'h0F0F, 0, 0, 17, 0);
    do_op(0, BASE, 16'hF0F0, 0, 0, 16, 0);
    // R8 held strobes
    do_op(0, BASE + 16'd2, 16'h5A5A, 0, 0, 0, 6);
    do_op(1, BASE + 16'd2, 16'h0000, 0, 0, 3, 6);

    // random mix
    void'($urandom(32'd1991));
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      int bl;
      a = BASE - 16'd3 + 16'($urandom_range(0, 2*NREG + 5));
      bl = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 25)) : 0;
      do_op(1'($urandom_range(0, 1)), a, 16'($urandom), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 4) == 0), bl, int'($urandom_range(0, 2)));
    end

    // R7 reset during a stretched cycle
    @(negedge clk);
    addr = BASE; aen = 1'b0; sbhe_n = 1'b0; data_in = 16'h1111; loc_busy = 1'b1; iow_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(chrdy == 1'b0, "R5 stretched before reset", chrdy, 0);
    reset_drv = 1'b1;
    #1;
    chk(chrdy == 1'b1, "R7 chrdy released by reset", chrdy, 1);
    for (int i = 0; i < NREG; i++) model[i] = 16'h0000;
    check_bank("R7 bank cleared mid-cycle");
    iow_n = 1'b1; loc_busy = 1'b0;
    @(negedge clk);
    reset_drv = 1'b0;
    repeat (2) @(negedge clk);
    check_bank("R7 bank after release");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule